// File: doc/BRIEF.md
# MDIO Paged 32-bit Register Bridge

This block lets a host read and write 32-bit registers that sit behind a clause-22 management bus. That bus carries only 16-bit values and a 5-bit register number. Each host request becomes a fixed series of three 16-bit transactions, all sent to one fixed PHY address. The first transaction always writes a page number taken from the upper register address bits into a page-select register. The two after it move the low and then the high half-word. A read-modify-write request runs a full read series, then a full write series carrying the merged value.

The host side is a valid/ready request port. `req_ready` is high only while the bridge is idle. A request is taken on the rising edge where `req_valid` and `req_ready` are both high. While an operation is in flight, `req_ready` stays low, so an upstream source has to hold its request until the bridge is idle again. Completion is shown by `rsp_done`, which is high for a single cycle. There is no back-pressure on the response: in the cycle that `rsp_done` is high, the host must take `rsp_rdata` and `rsp_err`.

The bus side is a plain command port toward a bit-level management master. Around each command the bridge polls the master's busy flag, and it gives up on any wait that runs past a parameterised number of cycles.

Top module: `mdio_reg_bridge`

## Requirements
- R1: Every command the bridge issues carries PHY address 0x1F.
- R2: Step one of every series is a write to register 0x1F. Its data is address bits [15:6], zero-extended to 16 bits.
- R3: The low half-word uses register number address bits [5:2]. The high half-word always uses register 0x10. Address bits [1:0] have no effect.
- R4: A write request (`req_op` = 01) issues three writes in this order: page select, `req_wdata[15:0]`, then `req_wdata[31:16]`. Its `rsp_rdata` is zero.
- R5: A read request (`req_op` = 00, and 11 is handled the same way) issues a page-select write, a read of the low half, then a read of the high half. It returns {high, low} on `rsp_rdata`.
- R6: A read-modify-write request (`req_op` = 10) first runs a full read series. It then runs a full write series with the value (old & ~`req_mask`) | `req_wdata`. Its `rsp_rdata` is the old value.
- R7: `mdio_start` is a one-cycle pulse. It is raised only after `mdio_busy` has been seen low, and never while `mdio_busy` is high.
- R8: After a command is issued, the step ends in the first cycle where `mdio_busy` is low. A read step takes `mdio_rdata` in that cycle.
- R9: A wait in which `mdio_busy` stays high for TIMEOUT_CYC cycles ends the step as timed out:
  - a read step that times out yields 0xFFFF;
  - a timed-out wait before issue sends no command;
  - the series carries on with its remaining steps, and `rsp_err` is 1 on completion;
  - `rsp_err` is cleared when the next request is accepted.
- R10: `req_ready` is high only when the bridge is idle. After an accept it drops on the next cycle. `rsp_done` is a single-cycle pulse, and `req_ready` returns the cycle after it.
- R11: After reset, `req_ready` is 1, and `rsp_done` and `mdio_start` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bridge idle, request can be taken |
| req_op | input | 2 | 00/11 read, 01 write, 10 read-modify-write |
| req_addr | input | ADDR_W | 32-bit register byte address |
| req_wdata | input | 32 | Write data, or set bits for read-modify-write |
| req_mask | input | 32 | Bits to clear in read-modify-write |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read result, valid with rsp_done |
| rsp_err | output | 1 | A step timed out, valid with rsp_done |
| mdio_start | output | 1 | Command strobe to the master |
| mdio_write | output | 1 | 1 for write command, 0 for read |
| mdio_phy | output | 5 | PHY address of command |
| mdio_reg | output | 5 | Register number of command |
| mdio_wdata | output | 16 | Write data of command |
| mdio_busy | input | 1 | Master busy |
| mdio_rdata | input | 16 | Read data from master |

## Verification
The embedded properties take three things for granted about the master:
- it raises `mdio_busy` on the edge that follows a `mdio_start`, so busy is already high in the first cycle of the after-issue wait;
- it never raises busy on its own while idle;
- `mdio_rdata` is stable from the moment busy falls.

The bench master is a registered model with a settable latency, and it follows these rules. The one exception is a separate "stuck" term ORed into busy. That term is set only before a request is sent and cleared only once the request has completed. Request fields are held steady while `req_valid` is high, and a new request is offered only after `rsp_done`.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;

  typedef enum logic [1:0] {
    OP_READ     = 2'b00,
    OP_WRITE    = 2'b01,
    OP_RMW      = 2'b10,
    OP_READ_ALT = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    STEP_PAGE = 2'd0,
    STEP_LOW  = 2'd1,
    STEP_HIGH = 2'd2
  } step_e;

  localparam logic [4:0] TARGET_PHY = 5'h1F;
  localparam logic [4:0] PAGE_REG   = 5'h1F;
  localparam logic [4:0] HIGH_REG   = 5'h10;
  localparam int         PAGE_LSB   = 6;
  localparam int         WORD_LSB   = 2;
  localparam int         WORD_W     = 4;

endpackage

// File: rtl/mdio_step_engine.sv
module mdio_step_engine
  import mdio_bridge_pkg::*;
#(
  parameter int TIMEOUT_CYC = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic        go_write,
  input  logic [4:0]  go_reg,
  input  logic [15:0] go_wdata,
  output logic        fin,
  output logic [15:0] fin_data,
  output logic        fin_timeout,
  output logic        cmd_start,
  output logic        cmd_write,
  output logic [4:0]  cmd_phy,
  output logic [4:0]  cmd_reg,
  output logic [15:0] cmd_wdata,
  input  logic        cmd_busy,
  input  logic [15:0] cmd_rdata
);

  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);

  typedef enum logic [1:0] {E_IDLE, E_PRE, E_ISSUE, E_POST} est_e;

  est_e              st;
  logic [CNT_W-1:0]  cnt;
  logic              wr_q;
  logic [4:0]        reg_q;
  logic [15:0]       wd_q;
  logic              at_limit;

  assign at_limit = (cnt == CNT_W'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= E_IDLE;
      cnt         <= '0;
      wr_q        <= 1'b0;
      reg_q       <= '0;
      wd_q        <= '0;
      fin         <= 1'b0;
      fin_data    <= '0;
      fin_timeout <= 1'b0;
    end else begin
      fin <= 1'b0;
      unique case (st)
        E_IDLE: begin
          if (go) begin
            wr_q  <= go_write;
            reg_q <= go_reg;
            wd_q  <= go_wdata;
            cnt   <= '0;
            st    <= E_PRE;
          end
        end
        E_PRE: begin
          if (!cmd_busy) begin
            st <= E_ISSUE;
          end else if (at_limit) begin
            fin         <= 1'b1;
            fin_timeout <= 1'b1;
            fin_data    <= 16'hFFFF;
            st          <= E_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        E_ISSUE: begin
          cnt <= '0;
          st  <= E_POST;
        end
        E_POST: begin
          if (!cmd_busy) begin
            fin         <= 1'b1;
            fin_timeout <= 1'b0;
            fin_data    <= wr_q ? 16'h0000 : cmd_rdata;
            st          <= E_IDLE;
          end else if (at_limit) begin
            fin         <= 1'b1;
            fin_timeout <= 1'b1;
            fin_data    <= 16'hFFFF;
            st          <= E_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= E_IDLE;
      endcase
    end
  end

  assign cmd_start = (st == E_ISSUE);
  assign cmd_write = wr_q;
  assign cmd_phy   = TARGET_PHY;
  assign cmd_reg   = reg_q;
  assign cmd_wdata = wd_q;

  // R7: strobe lasts one cycle and never overlaps a busy master
  assert_start_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> !cmd_start);
  assert_no_start_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> !cmd_busy);
  // R8: busy low after issue closes the step on the next edge
  assert_post_finish_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == E_POST && !cmd_busy) |=> (fin && !fin_timeout));
  // R9: wait counter never passes the limit
  assert_wait_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(TIMEOUT_CYC));

endmodule

// File: rtl/mdio_seq_ctrl.sv
module mdio_seq_ctrl
  import mdio_bridge_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [31:0]       req_mask,
  output logic              rsp_done,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic              go,
  output logic              go_write,
  output logic [4:0]        go_reg,
  output logic [15:0]       go_wdata,
  input  logic              fin,
  input  logic [15:0]       fin_data,
  input  logic              fin_timeout
);

  localparam int PAGE_W = ADDR_W - PAGE_LSB;

  typedef enum logic [1:0] {Q_IDLE, Q_LAUNCH, Q_WAIT, Q_DONE} qst_e;

  qst_e               st;
  step_e              step;
  logic               wr_phase;
  logic               rmw_q;
  logic               err_q;
  logic [PAGE_W-1:0]  page_q;
  logic [WORD_W-1:0]  word_q;
  logic [31:0]        wdata_q;
  logic [31:0]        mask_q;
  logic [15:0]        lo_q;
  logic [15:0]        hi_q;
  logic               accept;
  logic               addr_lsb_unused;

  assign addr_lsb_unused = ^req_addr[WORD_LSB-1:0];
  assign accept          = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= Q_IDLE;
      step     <= STEP_PAGE;
      wr_phase <= 1'b0;
      rmw_q    <= 1'b0;
      err_q    <= 1'b0;
      page_q   <= '0;
      word_q   <= '0;
      wdata_q  <= '0;
      mask_q   <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
    end else begin
      unique case (st)
        Q_IDLE: begin
          if (accept) begin
            page_q   <= req_addr[ADDR_W-1:PAGE_LSB];
            word_q   <= req_addr[WORD_LSB +: WORD_W];
            wdata_q  <= req_wdata;
            mask_q   <= req_mask;
            wr_phase <= (op_e'(req_op) == OP_WRITE);
            rmw_q    <= (op_e'(req_op) == OP_RMW);
            err_q    <= 1'b0;
            lo_q     <= '0;
            hi_q     <= '0;
            step     <= STEP_PAGE;
            st       <= Q_LAUNCH;
          end
        end
        Q_LAUNCH: st <= Q_WAIT;
        Q_WAIT: begin
          if (fin) begin
            err_q <= err_q | fin_timeout;
            if (!wr_phase && step == STEP_LOW)  lo_q <= fin_data;
            if (!wr_phase && step == STEP_HIGH) hi_q <= fin_data;
            if (step == STEP_HIGH) begin
              if (rmw_q && !wr_phase) begin
                wr_phase <= 1'b1;
                wdata_q  <= ({fin_data, lo_q} & ~mask_q) | wdata_q;
                step     <= STEP_PAGE;
                st       <= Q_LAUNCH;
              end else begin
                st <= Q_DONE;
              end
            end else begin
              step <= step_e'(step + 2'd1);
              st   <= Q_LAUNCH;
            end
          end
        end
        Q_DONE: st <= Q_IDLE;
        default: st <= Q_IDLE;
      endcase
    end
  end

  always_comb begin
    go       = (st == Q_LAUNCH);
    go_write = wr_phase || (step == STEP_PAGE);
    unique case (step)
      STEP_PAGE: begin
        go_reg   = PAGE_REG;
        go_wdata = 16'(page_q);
      end
      STEP_LOW: begin
        go_reg   = 5'(word_q);
        go_wdata = wdata_q[15:0];
      end
      default: begin
        go_reg   = HIGH_REG;
        go_wdata = wdata_q[31:16];
      end
    endcase
  end

  assign req_ready = (st == Q_IDLE);
  assign rsp_done  = (st == Q_DONE);
  assign rsp_rdata = {hi_q, lo_q};
  assign rsp_err   = err_q;

  // R10: an accepted request blocks the port on the next cycle
  assert_accept_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);
  // R10: completion is a single-cycle pulse, followed by idle
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> (!rsp_done && req_ready));
  // R2: step sequence never leaves its three slots
  assert_step_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    step != 2'd3);

endmodule

// File: rtl/mdio_reg_bridge.sv
module mdio_reg_bridge
  import mdio_bridge_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int TIMEOUT_CYC = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [31:0]       req_mask,
  output logic              rsp_done,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic              mdio_start,
  output logic              mdio_write,
  output logic [4:0]        mdio_phy,
  output logic [4:0]        mdio_reg,
  output logic [15:0]       mdio_wdata,
  input  logic              mdio_busy,
  input  logic [15:0]       mdio_rdata
);

  logic        go;
  logic        go_write;
  logic [4:0]  go_reg;
  logic [15:0] go_wdata;
  logic        fin;
  logic [15:0] fin_data;
  logic        fin_timeout;

  mdio_seq_ctrl #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_op     (req_op),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_mask   (req_mask),
    .rsp_done   (rsp_done),
    .rsp_rdata  (rsp_rdata),
    .rsp_err    (rsp_err),
    .go         (go),
    .go_write   (go_write),
    .go_reg     (go_reg),
    .go_wdata   (go_wdata),
    .fin        (fin),
    .fin_data   (fin_data),
    .fin_timeout(fin_timeout)
  );

  mdio_step_engine #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (go),
    .go_write   (go_write),
    .go_reg     (go_reg),
    .go_wdata   (go_wdata),
    .fin        (fin),
    .fin_data   (fin_data),
    .fin_timeout(fin_timeout),
    .cmd_start  (mdio_start),
    .cmd_write  (mdio_write),
    .cmd_phy    (mdio_phy),
    .cmd_reg    (mdio_reg),
    .cmd_wdata  (mdio_wdata),
    .cmd_busy   (mdio_busy),
    .cmd_rdata  (mdio_rdata)
  );

  // R1: commands leave with the fixed PHY address
  assert_fixed_phy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_start |-> (mdio_phy == TARGET_PHY));

endmodule

// File: tb/mdio_reg_bridge_test.sv
module mdio_reg_bridge_test;

  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = 2'b00;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] req_mask = '0;
  logic        rsp_done;
  logic [31:0] rsp_rdata;
  logic        rsp_err;
  logic        mdio_start;
  logic        mdio_write;
  logic [4:0]  mdio_phy;
  logic [4:0]  mdio_reg;
  logic [15:0] mdio_wdata;
  logic        mdio_busy;
  logic [15:0] mdio_rdata;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_reg_bridge #(.ADDR_W(16), .TIMEOUT_CYC(TMO)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .mdio_start(mdio_start), .mdio_write(mdio_write), .mdio_phy(mdio_phy),
    .mdio_reg(mdio_reg), .mdio_wdata(mdio_wdata),
    .mdio_busy(mdio_busy), .mdio_rdata(mdio_rdata)
  );

  // Management target model: page register plus paged half-word store
  logic [15:0] mem [int];
  logic [9:0]  cur_page = '0;
  logic        m_busy = 1'b0;
  int          m_cnt = 0;
  int          lat = 1;
  logic        stuck = 1'b0;
  logic [15:0] m_pend = '0;
  logic [15:0] m_rdata = '0;
  logic [26:0] lg [0:15];
  int          lg_n = 0;
  int          viol = 0;

  assign mdio_busy  = m_busy | stuck;
  assign mdio_rdata = m_rdata;

  always @(posedge clk) begin
    if (mdio_start && mdio_busy) viol <= viol + 1;
    if (!rst_n) begin
      m_busy <= 1'b0;
    end else if (mdio_start) begin
      int key;
      key = int'(cur_page) * 32 + int'(mdio_reg);
      if (lg_n < 16) lg[lg_n] = {mdio_write, mdio_phy, mdio_reg, mdio_wdata};
      lg_n = lg_n + 1;
      if (mdio_write) begin
        if (mdio_reg == 5'h1F) cur_page = mdio_wdata[9:0];
        else mem[key] = mdio_wdata;
      end else begin
        m_pend = mem.exists(key) ? mem[key] : 16'h0000;
      end
      m_busy <= 1'b1;
      m_cnt  <= lat;
    end else if (m_busy) begin
      if (m_cnt <= 1) begin
        m_busy  <= 1'b0;
        m_rdata <= m_pend;
      end else begin
        m_cnt <= m_cnt - 1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [26:0] ent(input logic wr, input logic [4:0] rg, input logic [15:0] d);
    return {wr, 5'h1F, rg, d};
  endfunction

  task automatic check_log(input int idx, input logic wr, input logic [4:0] rg,
                           input logic [15:0] d, input string tag);
    logic [26:0] e;
    e = ent(wr, rg, d);
    check(lg[idx] == e, tag, 32'(lg[idx]), 32'(e));
  endtask

  logic [31:0] got_data;
  logic        got_err;

  task automatic do_req(input logic [1:0] op, input logic [15:0] addr,
                        input logic [31:0] wd, input logic [31:0] mk);
    int n;
    lg_n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = wd; req_mask = mk;
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b0, "R10 ready low while busy", 32'(req_ready), 32'd0);
    n = 0;
    while (!rsp_done && n < 3000) begin
      @(negedge clk);
      n++;
    end
    got_data = rsp_rdata;
    got_err  = rsp_err;
    @(negedge clk);
    check(rsp_done == 1'b0 && req_ready == 1'b1, "R10 done single pulse, ready back",
          {30'd0, rsp_done, req_ready}, 32'd1);
  endtask

  function automatic logic [9:0] pg(input logic [15:0] a);
    return a[15:6];
  endfunction
  function automatic logic [4:0] lw(input logic [15:0] a);
    return {1'b0, a[5:2]};
  endfunction

  task automatic t_reset;
    check(req_ready == 1'b1, "R11 ready after reset", 32'(req_ready), 32'd1);
    check(rsp_done == 1'b0 && mdio_start == 1'b0, "R11 done/start low after reset",
          {30'd0, rsp_done, mdio_start}, 32'd0);
  endtask

  task automatic t_write(input logic [15:0] a, input logic [31:0] d);
    do_req(2'b01, a, d, 32'h0);
    check(lg_n == 3, "R4 write issues three commands", 32'(lg_n), 32'd3);
    check_log(0, 1'b1, 5'h1F, 16'(pg(a)), "R2 page select write (R1 phy)");
    check_log(1, 1'b1, lw(a), d[15:0], "R4 low half write at R3 register");
    check_log(2, 1'b1, 5'h10, d[31:16], "R4 high half write at R3 reg 0x10");
    check(got_err == 1'b0 && got_data == 32'h0, "R4 write response zero, no error",
          got_data, 32'h0);
  endtask

  task automatic t_read(input logic [1:0] op, input logic [15:0] a, input logic [31:0] exp, input string tag);
    do_req(op, a, 32'h0, 32'h0);
    check(lg_n == 3, {tag, " R5 three commands"}, 32'(lg_n), 32'd3);
    check_log(0, 1'b1, 5'h1F, 16'(pg(a)), {tag, " R2 page first"});
    check_log(1, 1'b0, lw(a), 16'h0, {tag, " R5 low read at R3 register"});
    check_log(2, 1'b0, 5'h10, 16'h0, {tag, " R5 high read at 0x10"});
    check(got_data == exp && !got_err, {tag, " R5 data"}, got_data, exp);
  endtask

  task automatic t_rmw(input logic [15:0] a, input logic [31:0] old, input logic [31:0] mk, input logic [31:0] st);
    logic [31:0] nv;
    nv = (old & ~mk) | st;
    do_req(2'b10, a, st, mk);
    check(lg_n == 6, "R6 rmw issues six commands", 32'(lg_n), 32'd6);
    check_log(3, 1'b1, 5'h1F, 16'(pg(a)), "R6 second page write");
    check_log(4, 1'b1, lw(a), nv[15:0], "R6 merged low half");
    check_log(5, 1'b1, 5'h10, nv[31:16], "R6 merged high half");
    check(got_data == old, "R6 returns old value", got_data, old);
    t_read(2'b00, a, nv, "R6 readback");
  endtask

  task automatic t_stuck(input logic [15:0] a);
    stuck = 1'b1;
    do_req(2'b00, a, 32'h0, 32'h0);
    stuck = 1'b0;
    check(lg_n == 0, "R9 pre-wait timeout issues nothing", 32'(lg_n), 32'd0);
    check(got_data == 32'hFFFF_FFFF, "R9 timed-out read value", got_data, 32'hFFFF_FFFF);
    check(got_err == 1'b1, "R9 error flag set", 32'(got_err), 32'd1);
  endtask

  task automatic t_post_timeout(input logic [15:0] a);
    lat = TMO + 4;
    do_req(2'b00, a, 32'h0, 32'h0);
    check(lg_n == 3, "R9 post timeout still runs all steps", 32'(lg_n), 32'd3);
    check(got_data == 32'hFFFF_FFFF && got_err, "R9 post timeout data and error",
          got_data, 32'hFFFF_FFFF);
    repeat (TMO + 10) @(negedge clk);
    lat = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();

    t_write(16'hABCD, 32'hDEAD_BEEF);
    t_write(16'h0044, 32'h1234_5678);
    t_read(2'b00, 16'hABCD, 32'hDEAD_BEEF, "R5 read page A");
    t_read(2'b00, 16'h0044, 32'h1234_5678, "R5 read page B");
    t_read(2'b00, 16'hABCE, 32'hDEAD_BEEF, "R3 low bits ignored");
    t_read(2'b11, 16'hABCF, 32'hDEAD_BEEF, "R5 op 11 as read");
    t_rmw(16'hABCD, 32'hDEAD_BEEF, 32'h0000_FFF0, 32'h0000_0005);

    lat = 6;
    t_read(2'b00, 16'h0044, 32'h1234_5678, "R8 slow master");
    lat = 1;

    t_stuck(16'h0044);
    t_read(2'b00, 16'h0044, 32'h1234_5678, "R9 error clears next request");
    t_post_timeout(16'h0044);

    check(viol == 0, "R7 no start while busy", 32'(viol), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule